// File: doc/BRIEF.md
# Up/Down Pulse Counter with Edge-Triggered Compare Status

This block counts pulses that arrive on an asynchronous input. The input is brought into the system clock domain by a short flip-flop chain, and each rising edge found after that chain moves the count by one. A direction input chooses whether the count goes up or down. The running count is tested against a programmable compare value, using one of five relational modes. A registered compare output shows the result of that test on every cycle.

Two status bits are sticky. The first one records the cycle in which the compare condition changes from false to true. The second one records a wrap of the count in either direction. If the condition just stays true, the first bit is not set again. A mode such as greater-or-equal, where the count keeps rising past the compare value, behaves the same way. A small register port lets software do four things: load the count (for example to zero after homing), set the compare value, choose the mode and the interrupt mask, and read the status. Reading the status clears it. The registered interrupt output is high while any sticky bit whose mask bit is set is itself set.

Top module: `updown_cmp_counter`

## Requirements
- R1: Each rising edge of `count_in` changes the count by one, three clock edges after the edge. The count goes up when `up_dn`=1 and down when `up_dn`=0, and it wraps modulo 2^16.
- R2: `cmp_out` equals the compare condition of the previous cycle, so it is high one cycle after the condition becomes true.
- R3: Mode field codes: 000 count==compare, 001 count<compare, 010 count<=compare, 011 count>compare, 100 count>=compare. Codes 101 to 111 make the condition false. The comparison is unsigned.
- R4: Status bit 0 is set in the cycle in which the compare condition goes from false to true.
- R5: A condition that stays true does not set status bit 0 again after it has been cleared.
- R6: A read of address 3 returns status bit 0 (compare event), bit 1 (wrap) and bit 2 (live `cmp_out`). The same read clears bits 0 and 1. The read data is registered and is valid one cycle after `reg_rd`.
- R7: If a compare event or a wrap happens in the same cycle as a status read, the bit is set after the read. The read still returns the value the bit had before the event.
- R8: `irq` is registered and equals the OR of (status bit 0 AND mask bit 0) and (status bit 1 AND mask bit 1). The mask is held in bits 5:4 of the control register at address 2.
- R9: A write to address 0 loads the count. The load takes priority over a count step in the same cycle, and the count reads back from address 0.
- R10: Status bit 1 is set when a step moves the count from 0xFFFF up to 0 or from 0 down to 0xFFFF.
- R11: After reset: count 0, compare value 0xFFFF, mode and mask 0, status 0, and `cmp_out`, `irq` and read data all 0.
- R12: Writing a compare value (address 1) that makes the condition false drops `cmp_out`. When counting later makes the condition true again, bit 0 is set once more and `irq` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| count_in | input | 1 | Asynchronous count pulse input |
| up_dn | input | 1 | Count direction: 1 up, 0 down |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 count, 1 compare, 2 control, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| cmp_out | output | 1 | Registered compare condition |
| irq | output | 1 | Registered masked interrupt |

## Verification
The assertions check on every cycle the rules that are local in time. These are: `cmp_out` lags the condition by one cycle, a false-to-true change sets bit 0, a level that stays true leaves a cleared bit 0 clear, a status read clears bit 0 unless an event coincides with it, a count load takes effect, and `irq` matches the masked sticky bits. Other behaviours need a whole scenario, and only the bench's scenarios can show them. These include the per-mode truth table, wraps in both directions, the full sequence of homing, clear, moving the compare value and re-arming the interrupt, and a read that lands in the same cycle as an event. The bench checks these against a behavioural model on every clock.

// File: rtl/cmpctr_pkg.sv
package cmpctr_pkg;
  typedef enum logic [2:0] {
    CMP_EQ = 3'b000,
    CMP_LT = 3'b001,
    CMP_LE = 3'b010,
    CMP_GT = 3'b011,
    CMP_GE = 3'b100
  } cmp_mode_e;

  localparam int MODE_W    = 3;
  localparam int STAT_W    = 2;
  localparam int MASK_LSB  = 4;
  localparam int REG_ADR_W = 2;

  localparam logic [REG_ADR_W-1:0] ADR_COUNT = 2'd0;
  localparam logic [REG_ADR_W-1:0] ADR_CMP   = 2'd1;
  localparam logic [REG_ADR_W-1:0] ADR_CTRL  = 2'd2;
  localparam logic [REG_ADR_W-1:0] ADR_STAT  = 2'd3;
endpackage

// File: rtl/cmpctr_pulse_sync.sv
module cmpctr_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  // STAGES flops for metastability, one more to find the edge
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/cmpctr_counter.sv
module cmpctr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         up,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic at_top, at_bottom;

  assign at_top    = &count;
  assign at_bottom = ~|count;
  assign wrap      = step & ~load & (up ? at_top : at_bottom);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= up ? count + 1'b1 : count - 1'b1;
  end
endmodule

// File: rtl/cmpctr_compare.sv
module cmpctr_compare
  import cmpctr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]      value,
  input  logic [W-1:0]      ref_val,
  input  logic [MODE_W-1:0] mode,
  output logic              hit
);
  always_comb begin
    case (mode)
      CMP_EQ:  hit = (value == ref_val);
      CMP_LT:  hit = (value <  ref_val);
      CMP_LE:  hit = (value <= ref_val);
      CMP_GT:  hit = (value >  ref_val);
      CMP_GE:  hit = (value >= ref_val);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/updown_cmp_counter.sv
module updown_cmp_counter
  import cmpctr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 count_in,
  input  logic                 up_dn,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_ADR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata,
  output logic                 cmp_out,
  output logic                 irq
);
  localparam int CTRL_USED = MASK_LSB + STAT_W;
  localparam int STAT_USED = STAT_W + 1;

  logic              step, wrap, cond_now, cond_q, irq_q;
  logic [CNT_W-1:0]  count_q, cmp_q, rdata_q;
  logic [MODE_W-1:0] mode_q;
  logic [STAT_W-1:0] mask_q, mask_d, sticky_q, sticky_d, set_vec;
  logic              load, wr_cmp, wr_ctrl, rd_stat;

  assign load    = reg_wr && reg_addr == ADR_COUNT;
  assign wr_cmp  = reg_wr && reg_addr == ADR_CMP;
  assign wr_ctrl = reg_wr && reg_addr == ADR_CTRL;
  assign rd_stat = reg_rd && reg_addr == ADR_STAT;

  cmpctr_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(count_in), .rise(step)
  );

  cmpctr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(reg_wdata),
    .step(step), .up(up_dn), .count(count_q), .wrap(wrap)
  );

  cmpctr_compare #(.W(CNT_W)) u_cmp (
    .value(count_q), .ref_val(cmp_q), .mode(mode_q), .hit(cond_now)
  );

  // bit 0: condition edge, bit 1: wrap; setting wins over a read clear
  assign set_vec  = {wrap, cond_now & ~cond_q};
  assign sticky_d = (rd_stat ? '0 : sticky_q) | set_vec;
  assign mask_d   = wr_ctrl ? reg_wdata[MASK_LSB +: STAT_W] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q    <= '1;
      mode_q   <= '0;
      mask_q   <= '0;
      sticky_q <= '0;
      cond_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_cmp)  cmp_q  <= reg_wdata;
      if (wr_ctrl) mode_q <= reg_wdata[MODE_W-1:0];
      mask_q   <= mask_d;
      sticky_q <= sticky_d;
      cond_q   <= cond_now;
      irq_q    <= |(sticky_d & mask_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        ADR_COUNT: rdata_q <= count_q;
        ADR_CMP:   rdata_q <= cmp_q;
        ADR_CTRL:  rdata_q <= {{(CNT_W-CTRL_USED){1'b0}}, mask_q, 1'b0, mode_q};
        default:   rdata_q <= {{(CNT_W-STAT_USED){1'b0}}, cond_q, sticky_q};
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign cmp_out   = cond_q;
  assign irq       = irq_q;
endmodule

// File: rtl/cmpctr_checker.sv
module cmpctr_checker
  import cmpctr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic [REG_ADR_W-1:0] reg_addr,
  input logic [CNT_W-1:0]     reg_wdata,
  input logic [CNT_W-1:0]     count,
  input logic                 cond_now,
  input logic                 cmp_out,
  input logic [STAT_W-1:0]    sticky,
  input logic [STAT_W-1:0]    mask,
  input logic                 irq
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  assert_cmp_lags_R2: assert property (@(posedge clk) disable iff (rst)
    seen |-> cmp_out == $past(cond_now));

  assert_edge_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (cond_now && !cmp_out) |=> sticky[0]);

  assert_level_no_set_R5: assert property (@(posedge clk) disable iff (rst)
    (cond_now && cmp_out && !sticky[0]) |=> !sticky[0]);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADR_STAT && !(cond_now && !cmp_out)) |=> !sticky[0]);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    seen |-> irq == |(sticky & mask));

  assert_load_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADR_COUNT) |=> count == $past(reg_wdata));
endmodule

bind updown_cmp_counter cmpctr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .count(count_q),
  .cond_now(cond_now), .cmp_out(cmp_out), .sticky(sticky_q),
  .mask(mask_q), .irq(irq)
);

// File: tb/updown_cmp_counter_bench.sv
module updown_cmp_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        count_in = 1'b0, up_dn = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        cmp_out, irq;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  updown_cmp_counter u_updown_cmp_counter (
    .clk(clk), .rst(rst), .count_in(count_in), .up_dn(up_dn),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmp_out(cmp_out), .irq(irq)
  );

  // behavioural reference model
  int m_cnt, m_cmp, m_mode, m_mask, m_st0, m_st1, m_condq, m_irq, m_rdata;
  int s1, s2, s3;

  function automatic int cond_of(int c, int r, int md);
    if (md == 0) return int'(c == r);
    if (md == 1) return int'(c <  r);
    if (md == 2) return int'(c <= r);
    if (md == 3) return int'(c >  r);
    if (md == 4) return int'(c >= r);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cmp = 65535; m_mode = 0; m_mask = 0; m_st0 = 0; m_st1 = 0;
      m_condq = 0; m_irq = 0; m_rdata = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int rise, cnow, wrapv, ld;
      rise = int'(s2 == 1 && s3 == 0);
      s3 = s2; s2 = s1; s1 = int'(count_in);
      cnow = cond_of(m_cnt, m_cmp, m_mode);
      ld = int'(reg_wr && reg_addr == 2'd0);
      wrapv = int'(rise == 1 && ld == 0 && (up_dn ? m_cnt == 65535 : m_cnt == 0));
      if (reg_rd) begin
        case (reg_addr)
          2'd0: m_rdata = m_cnt;
          2'd1: m_rdata = m_cmp;
          2'd2: m_rdata = m_mode + 16 * m_mask;
          default: m_rdata = m_st0 + 2 * m_st1 + 4 * m_condq;
        endcase
        if (reg_addr == 2'd3) begin m_st0 = 0; m_st1 = 0; end
      end
      if (cnow == 1 && m_condq == 0) m_st0 = 1;
      if (wrapv == 1) m_st1 = 1;
      if (reg_wr && reg_addr == 2'd2) begin
        m_mode = int'(reg_wdata) % 8; m_mask = (int'(reg_wdata) / 16) % 4;
      end
      if (reg_wr && reg_addr == 2'd1) m_cmp = int'(reg_wdata);
      if (ld == 1) m_cnt = int'(reg_wdata);
      else if (rise == 1) m_cnt = up_dn ? (m_cnt + 1) % 65536 : (m_cnt + 65535) % 65536;
      m_condq = cnow;
      m_irq = int'((m_st0 == 1 && m_mask % 2 == 1) || (m_st1 == 1 && m_mask / 2 == 1));
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison with the model
  always @(negedge clk) begin
    chk("R2 cmp_out vs model", int'(cmp_out), m_condq);
    chk("R8 irq vs model", int'(irq), m_irq);
    chk("R6 rdata vs model", int'(reg_rdata), m_rdata);
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; v = int'(reg_rdata);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); count_in = 1'b1;
      repeat (2) @(negedge clk); count_in = 1'b0;
      repeat (1) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset values
    chk("R11 cmp_out", int'(cmp_out), 0);
    chk("R11 irq", int'(irq), 0);
    rd(2'd0, v); chk("R11 count", v, 0);
    rd(2'd1, v); chk("R11 compare", v, 65535);
    rd(2'd2, v); chk("R11 control", v, 0);
    rd(2'd3, v); chk("R11 status", v, 0);

    // homing: load count onto compare value
    wr(2'd2, 16'h0030);
    wr(2'd1, 16'd5);
    wr(2'd0, 16'd5);
    idle(2);
    chk("R2 cmp high after load", int'(cmp_out), 1);
    chk("R4 irq on rise", int'(irq), 1);
    rd(2'd0, v); chk("R9 loaded count", v, 5);
    rd(2'd3, v); chk("R6 status read", v, 5);
    idle(5);
    chk("R5 no re-set while true", int'(irq), 0);
    rd(2'd3, v); chk("R5 status stays clear", v, 4);

    // move compare away, then count up to it
    wr(2'd1, 16'd8);
    idle(2);
    chk("R12 cmp drops", int'(cmp_out), 0);
    up_dn = 1'b1;
    pulses(3);
    chk("R12 cmp back", int'(cmp_out), 1);
    chk("R12 irq again", int'(irq), 1);
    rd(2'd3, v); chk("R12 status", v, 5);

    // greater-or-equal while counting past
    wr(2'd2, 16'h0034);
    wr(2'd1, 16'd10);
    idle(2);
    chk("R3 GE false at 8", int'(cmp_out), 0);
    pulses(2);
    chk("R4 GE rise irq", int'(irq), 1);
    rd(2'd3, v); chk("R4 GE status", v, 5);
    pulses(3);
    chk("R5 GE no re-set irq", int'(irq), 0);
    rd(2'd3, v); chk("R5 GE status", v, 4);
    rd(2'd0, v); chk("R1 count up", v, 13);

    // mode truth table, count 13
    wr(2'd1, 16'd13);
    for (int md = 0; md < 8; md++) begin
      int exp13;
      exp13 = (md == 0 || md == 2 || md == 4) ? 1 : 0;
      wr(2'd2, 16'(md));
      idle(2);
      chk("R3 mode vs equal value", int'(cmp_out), exp13);
    end
    wr(2'd1, 16'd20);
    for (int md = 0; md < 5; md++) begin
      int exp20;
      exp20 = (md == 1 || md == 2) ? 1 : 0;
      wr(2'd2, 16'(md));
      idle(2);
      chk("R3 mode vs larger value", int'(cmp_out), exp20);
    end

    // down counting
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd100);
    up_dn = 1'b0;
    pulses(4);
    rd(2'd0, v); chk("R1 count down", v, 96);
    up_dn = 1'b1;
    pulses(2);
    rd(2'd0, v); chk("R1 count up again", v, 98);

    // wraps
    rd(2'd3, v);
    wr(2'd0, 16'hFFFF);
    pulses(1);
    rd(2'd0, v); chk("R1 wrap to zero", v, 0);
    rd(2'd3, v); chk("R10 up wrap status", v, 2);
    up_dn = 1'b0;
    pulses(1);
    rd(2'd0, v); chk("R1 wrap to max", v, 65535);
    rd(2'd3, v); chk("R10 down wrap status", v, 2);

    // mask
    wr(2'd2, 16'h0010);
    wr(2'd0, 16'd0);
    pulses(1);
    chk("R8 masked wrap no irq", int'(irq), 0);
    wr(2'd2, 16'h0030);
    idle(1);
    chk("R8 unmask raises irq", int'(irq), 1);
    rd(2'd3, v); chk("R10 wrap held", v, 2);
    chk("R8 irq after clear", int'(irq), 0);

    // status read in the same cycle as a compare rise
    wr(2'd0, 16'd50);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'd50;
    @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = 2'd3;
    @(negedge clk); reg_rd = 1'b0; v = int'(reg_rdata);
    chk("R7 read sees old status", v, 0);
    chk("R7 irq survives read", int'(irq), 1);
    rd(2'd3, v); chk("R7 event kept", v, 5);

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule